// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block drives the digital timing that empties a full-frame CCD once an exposure has ended. A single start request opens a frame. The block first holds both vertical phases low for the programmed integration time. It then repeats a two-part cycle for every line. In the first part, a non-overlapping two-phase vertical pulse drops one line into the horizontal register. In the second part, complementary horizontal clocks walk that line to the sense node one packet at a time.

Each time H1 falls, one packet reaches the sense node. The block raises a sample strobe in the cycle that follows that fall. In the cycle after the sample, it pulses the reset gate to clear the sense node. Every delivered packet is tagged as a leading dummy, a shielded dark pixel or an active pixel. Horizontal binning is done at the output node: the block leaves out the reset pulses between the packets of one group and strobes once per group.

Start settings are the exposure length, the number of active rows, the number of active columns, the binning factor and the vertical idle width. All of them are captured when the start request is accepted. The frame shape is fixed around these settings: every frame has four dark lines at the top and four at the bottom, and every line has 4.5 dummy periods followed by four dark columns.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset and while idle, the outputs are v1=0, v2=0, h1=1, h2=0, rg=0, sample=0, tag=0, busy=0 and frame_done=0.
- R2: After start is accepted, busy rises and both vertical clocks stay low for exactly exposure+1 cycles. The first line transfer follows immediately.
- R3: A line transfer has four steps, each lasting gap+1 cycles, in this order: v1 high, both low, v2 high, both low. v1 and v2 are never high together, and h1 stays high with h2 low for the whole transfer.
- R4: Whenever v2 falls, h1 is high.
- R5: During shifting, h1 and h2 alternate every cycle and are always opposite. Each line gives exactly 9+cols falling edges of h1.
- R6: sample is high only in the cycle right after a falling edge of h1. The first five falling edges of a line deliver dummies (the first is the half-period dummy) and are never sampled. The first strobe of a line follows the sixth falling edge.
- R7: The reset gate pulses in the cycle right after every sample strobe and after every dummy edge, and never in the same cycle as a strobe.
- R8: tag is valid in the cycle after each h1 falling edge and is 0 in all other cycles. The codes are 1 for a dummy edge (edges 1 to 5), 2 for dark and 3 for active. A packet is dark when it is on edges 6 to 9, or when it is in one of the first four or last four lines of the frame.
- R9: Active columns are grouped by the binning factor, with 0 treated as 1. Within each group, only the last packet gets a strobe and a reset pulse. A short group at the end of a line is closed at the line's last column.
- R10: After the last packet of the final dark line, frame_done is high for one cycle, and busy falls in the next cycle.
- R11: A start request that arrives while busy is high has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, accepted only while idle |
| exp_len_i | input | EXP_W | Integration length in cycles (the hold is this value + 1) |
| rows_i | input | ROW_W | Number of active rows |
| cols_i | input | COL_W | Number of active columns |
| bin_i | input | BIN_W | Horizontal binning factor (0 acts as 1) |
| gap_i | input | GAP_W | Vertical step width minus one |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| rg_o | output | 1 | Reset gate pulse |
| sample_o | output | 1 | Sample strobe for the packet on the sense node |
| tag_o | output | 2 | Packet class: 0 none, 1 dummy, 2 dark, 3 active |
| busy_o | output | 1 | High from start acceptance through frame_done |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench counts h1 falling edges within each line and checks that the first strobe lands on the sixth. A design that strobed the half-period dummy, or that skipped it, would be off by one edge and would also get every packet total wrong.

The bench also runs a binning factor that does not divide the column count, a factor of zero, and a factor larger than the line. Here a wrong design would strobe in the middle of a group or let a partial group spill into the next line. A frame made only of dark lines exercises the row tagging. A start pulse in the middle of a frame would show up as a second frame_done or a longer busy period if it were not ignored. Step-width measurements on v1 and v2 catch phases that overlap, or a line that lands while h1 is low.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_EXPOSE = 3'd1,
        ST_VXFER  = 3'd2,
        ST_HSHIFT = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        TAG_NONE   = 2'd0,
        TAG_DUMMY  = 2'd1,
        TAG_DARK   = 2'd2,
        TAG_ACTIVE = 2'd3
    } pix_tag_e;

    // Leading horizontal edges that carry no column data (half period + 4 full)
    localparam int DUMMY_EDGES = 5;
    // Shielded columns at the head of every line
    localparam int DARK_COLS   = 4;
    // Shielded lines at each end of the frame
    localparam int DARK_ROWS   = 4;
    // Vertical transfer steps: v1 high, idle, v2 high, idle
    localparam int VSTEPS      = 4;

endpackage

// File: rtl/ccdseq_vphase.sv
module ccdseq_vphase (
    input  logic       in_xfer_i,
    input  logic [1:0] vstep_i,
    output logic       v1_o,
    output logic       v2_o
);
    // Step 0 drives phase 1, step 2 drives phase 2; steps 1 and 3 keep both low
    always_comb begin
        v1_o = in_xfer_i && (vstep_i == 2'd0);
        v2_o = in_xfer_i && (vstep_i == 2'd2);
    end
endmodule

// File: rtl/ccdseq_tagger.sv
module ccdseq_tagger
    import ccdseq_pkg::*;
#(
    parameter int EDGE_W = 8,
    parameter int LINE_W = 8,
    parameter int ROW_W  = 6,
    parameter int COL_W  = 6,
    parameter int BIN_W  = 3
) (
    input  logic              shifting_i,
    input  logic              phase_i,
    input  logic [EDGE_W-1:0] edge_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [ROW_W-1:0]  rows_i,
    input  logic [COL_W-1:0]  cols_i,
    input  logic [BIN_W-1:0]  bin_i,
    input  logic [BIN_W-1:0]  bcnt_i,
    output logic              grp_end_o,
    output logic              sample_o,
    output logic              rg_o,
    output pix_tag_e          tag_o
);
    localparam logic [EDGE_W-1:0] LAST_DUMMY = EDGE_W'(DUMMY_EDGES);
    localparam logic [EDGE_W-1:0] LAST_DARK  = EDGE_W'(DUMMY_EDGES + DARK_COLS);

    logic in_dummy, in_darkcol, dark_row, last_col;

    always_comb begin
        in_dummy   = edge_i <= LAST_DUMMY;
        in_darkcol = !in_dummy && (edge_i <= LAST_DARK);
        dark_row   = (line_i < LINE_W'(DARK_ROWS)) ||
                     (line_i >= LINE_W'(rows_i) + LINE_W'(DARK_ROWS));
        last_col   = edge_i == (EDGE_W'(cols_i) + LAST_DARK);
        grp_end_o  = in_dummy || in_darkcol || last_col ||
                     (bcnt_i == bin_i - BIN_W'(1));
        sample_o   = shifting_i && !phase_i && !in_dummy && grp_end_o;
        rg_o       = shifting_i && phase_i && grp_end_o;
        if (!shifting_i || phase_i)
            tag_o = TAG_NONE;
        else if (in_dummy)
            tag_o = TAG_DUMMY;
        else if (in_darkcol || dark_row)
            tag_o = TAG_DARK;
        else
            tag_o = TAG_ACTIVE;
    end
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
    import ccdseq_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int EXP_W = 20,
    parameter int BIN_W = 3,
    parameter int GAP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [EXP_W-1:0] exp_len_i,
    input  logic [ROW_W-1:0] rows_i,
    input  logic [COL_W-1:0] cols_i,
    input  logic [BIN_W-1:0] bin_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             v1_o,
    output logic             v2_o,
    output logic             h1_o,
    output logic             h2_o,
    output logic             rg_o,
    output logic             sample_o,
    output logic [1:0]       tag_o,
    output logic             busy_o,
    output logic             frame_done_o
);
    localparam int EDGE_W = COL_W + 2;
    localparam int LINE_W = ROW_W + 2;
    localparam logic [EDGE_W-1:0] LAST_DARK = EDGE_W'(DUMMY_EDGES + DARK_COLS);

    typedef struct packed {
        seq_state_e        st;
        logic [EXP_W-1:0]  exp_cnt;
        logic [1:0]        vstep;
        logic [GAP_W-1:0]  hold;
        logic [EDGE_W-1:0] edge_n;
        logic              phase;
        logic [LINE_W-1:0] line;
        logic [BIN_W-1:0]  bcnt;
        logic [ROW_W-1:0]  rows;
        logic [COL_W-1:0]  cols;
        logic [BIN_W-1:0]  bin;
        logic [GAP_W-1:0]  gap;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      grp_end, shifting;
    pix_tag_e  tag_w;

    assign shifting = (r_q.st == ST_HSHIFT);

    ccdseq_vphase u_vphase (
        .in_xfer_i (r_q.st == ST_VXFER),
        .vstep_i   (r_q.vstep),
        .v1_o      (v1_o),
        .v2_o      (v2_o)
    );

    ccdseq_tagger #(
        .EDGE_W (EDGE_W),
        .LINE_W (LINE_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .BIN_W  (BIN_W)
    ) u_tagger (
        .shifting_i (shifting),
        .phase_i    (r_q.phase),
        .edge_i     (r_q.edge_n),
        .line_i     (r_q.line),
        .rows_i     (r_q.rows),
        .cols_i     (r_q.cols),
        .bin_i      (r_q.bin),
        .bcnt_i     (r_q.bcnt),
        .grp_end_o  (grp_end),
        .sample_o   (sample_o),
        .rg_o       (rg_o),
        .tag_o      (tag_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st      = ST_EXPOSE;
                    r_d.exp_cnt = exp_len_i;
                    r_d.rows    = rows_i;
                    r_d.cols    = cols_i;
                    r_d.bin     = (bin_i == '0) ? BIN_W'(1) : bin_i;
                    r_d.gap     = gap_i;
                end
            end
            ST_EXPOSE: begin
                if (r_q.exp_cnt == '0) begin
                    r_d.st    = ST_VXFER;
                    r_d.vstep = 2'd0;
                    r_d.hold  = '0;
                    r_d.line  = '0;
                end else begin
                    r_d.exp_cnt = r_q.exp_cnt - EXP_W'(1);
                end
            end
            ST_VXFER: begin
                if (r_q.hold == r_q.gap) begin
                    r_d.hold = '0;
                    if (r_q.vstep == 2'(VSTEPS - 1)) begin
                        r_d.st     = ST_HSHIFT;
                        r_d.edge_n = EDGE_W'(1);
                        r_d.phase  = 1'b0;
                        r_d.bcnt   = '0;
                    end else begin
                        r_d.vstep = r_q.vstep + 2'd1;
                    end
                end else begin
                    r_d.hold = r_q.hold + GAP_W'(1);
                end
            end
            ST_HSHIFT: begin
                if (!r_q.phase) begin
                    r_d.phase = 1'b1;
                end else begin
                    r_d.phase = 1'b0;
                    if (r_q.edge_n > LAST_DARK)
                        r_d.bcnt = grp_end ? '0 : r_q.bcnt + BIN_W'(1);
                    if (r_q.edge_n == EDGE_W'(r_q.cols) + LAST_DARK) begin
                        if (r_q.line == LINE_W'(r_q.rows) + LINE_W'(2 * DARK_ROWS - 1)) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.st    = ST_VXFER;
                            r_d.line  = r_q.line + LINE_W'(1);
                            r_d.vstep = 2'd0;
                            r_d.hold  = '0;
                        end
                    end else begin
                        r_d.edge_n = r_q.edge_n + EDGE_W'(1);
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign h2_o         = shifting && !r_q.phase;
    assign h1_o         = !h2_o;
    assign tag_o        = tag_w;
    assign busy_o       = (r_q.st != ST_IDLE);
    assign frame_done_o = (r_q.st == ST_DONE);

    AST_LINE_LAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(v2_o) |-> h1_o); // R4
    AST_SAMPLE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> $fell(h1_o)); // R6
    AST_RG_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> (rg_o && !sample_o)); // R7
    AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> !busy_o); // R10
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !frame_done_o) |=> busy_o); // R11
    AST_VLOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!v1_o && !v2_o && h1_o && !h2_o && !rg_o)); // R1
endmodule

// File: tb/sim_ccd_readout_seq.sv
module sim_ccd_readout_seq;
    localparam int ROW_W = 6;
    localparam int COL_W = 6;
    localparam int EXP_W = 8;
    localparam int BIN_W = 3;
    localparam int GAP_W = 3;
    localparam int NVEC  = 5;

    // Stimulus vectors: rows, cols, bin, exposure, gap
    localparam int V_ROWS [NVEC] = '{2, 3, 1, 2, 0};
    localparam int V_COLS [NVEC] = '{4, 7, 6, 5, 3};
    localparam int V_BIN  [NVEC] = '{1, 3, 2, 0, 4};
    localparam int V_EXP  [NVEC] = '{3, 0, 10, 1, 2};
    localparam int V_GAP  [NVEC] = '{0, 1, 2, 0, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [EXP_W-1:0] exp_len = '0;
    logic [ROW_W-1:0] rows = '0;
    logic [COL_W-1:0] cols = '0;
    logic [BIN_W-1:0] bin = '0;
    logic [GAP_W-1:0] gap = '0;
    logic v1, v2, h1, h2, rg, sample, busy, frame_done;
    logic [1:0] tag;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ccd_readout_seq #(
        .ROW_W (ROW_W), .COL_W (COL_W), .EXP_W (EXP_W), .BIN_W (BIN_W), .GAP_W (GAP_W)
    ) u0 (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .exp_len_i (exp_len),
        .rows_i (rows), .cols_i (cols), .bin_i (bin), .gap_i (gap),
        .v1_o (v1), .v2_o (v2), .h1_o (h1), .h2_o (h2), .rg_o (rg),
        .sample_o (sample), .tag_o (tag), .busy_o (busy), .frame_done_o (frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one frame and check its totals; mid_start pulses start during the frame
    task automatic run_frame(input int r, input int c, input int b, input int e,
                             input int g, input bit mid_start);
        int beff, grp, lines, npix;
        int busy_c, exp_c, samp_c, act_c, dark_c, dum_c, rg_c, done_c, fall_c, cyc;
        int v1r, v1f, bad_ov, bad_cmp, bad_land, bad_samp, bad_first, bad_rg;
        int bad_vw, bad_gap, bad_tag, bad_exp;
        bit seen_v1, first_in_line, p_h1, p_v1, p_v2, p_samp, out;
        beff = (b == 0) ? 1 : b;
        grp = (c + beff - 1) / beff;
        lines = r + 8;
        npix = 9 + c;
        busy_c = 0; exp_c = 0; samp_c = 0; act_c = 0; dark_c = 0; dum_c = 0;
        rg_c = 0; done_c = 0; fall_c = 0; cyc = 0; v1r = 0; v1f = 0;
        bad_ov = 0; bad_cmp = 0; bad_land = 0; bad_samp = 0; bad_first = 0;
        bad_rg = 0; bad_vw = 0; bad_gap = 0; bad_tag = 0; bad_exp = 0;
        seen_v1 = 0; first_in_line = 0; p_h1 = 1; p_v1 = 0; p_v2 = 0; p_samp = 0;
        out = 0;
        @(negedge clk);
        rows = ROW_W'(r); cols = COL_W'(c); bin = BIN_W'(b);
        exp_len = EXP_W'(e); gap = GAP_W'(g); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!out && cyc < 20000) begin
            cyc++;
            if (busy) busy_c++;
            if (busy && !seen_v1 && !v1) begin
                exp_c++;
                if (v2) bad_exp++;
            end
            if (v1 && !p_v1) begin
                seen_v1 = 1; v1r = cyc; fall_c = 0; first_in_line = 1;
            end
            if (!v1 && p_v1) begin
                v1f = cyc;
                if (v1f - v1r != g + 1) bad_vw++;
            end
            if (v2 && !p_v2 && (cyc - v1f != g + 1)) bad_gap++;
            if (v1 && v2) bad_ov++;
            if ((v1 || v2) && (!h1 || h2)) bad_ov++;
            if (h1 == h2) bad_cmp++;
            if (!v2 && p_v2 && !h1) bad_land++;
            if (p_h1 && !h1) fall_c++;
            if (sample) begin
                samp_c++;
                if (h1 || !p_h1) bad_samp++;
                if (first_in_line && fall_c != 6) bad_first++;
                first_in_line = 0;
                if (tag == 2'd3) act_c++;
                else if (tag == 2'd2) dark_c++;
                else bad_tag++;
                if (rg) bad_rg++;
            end
            if (tag == 2'd1) begin
                dum_c++;
                if (sample || fall_c > 5) bad_tag++;
            end
            if (tag != 2'd0 && !(p_h1 && !h1)) bad_tag++;
            if (rg) rg_c++;
            if (p_samp && !rg) bad_rg++;
            if (frame_done) begin
                done_c++;
                out = 1;
            end
            if (mid_start) start = (cyc == 30);
            p_h1 = h1; p_v1 = v1; p_v2 = v2; p_samp = sample;
            if (!out) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk(!busy && !frame_done, "R10 idle after frame_done", int'(busy), 0);
        chk(done_c == 1, "R10/R11 frame_done count", done_c, 1);
        chk(busy_c == e + 1 + lines * (4 * (g + 1) + 2 * npix) + 1,
            "R11 busy length", busy_c, e + 1 + lines * (4 * (g + 1) + 2 * npix) + 1);
        chk(exp_c == e + 1 && bad_exp == 0, "R2 integration hold", exp_c, e + 1);
        chk(bad_ov == 0 && bad_vw == 0 && bad_gap == 0, "R3 vertical steps",
            bad_ov + bad_vw + bad_gap, 0);
        chk(bad_land == 0, "R4 line lands with h1 high", bad_land, 0);
        chk(bad_cmp == 0, "R5 complementary h clocks", bad_cmp, 0);
        chk(bad_samp == 0 && bad_first == 0, "R6 strobe placement",
            bad_samp + bad_first, 0);
        chk(bad_rg == 0 && rg_c == lines * (9 + grp), "R7 reset gate pulses",
            rg_c, lines * (9 + grp));
        chk(bad_tag == 0 && dum_c == 5 * lines, "R8 dummy tags", dum_c, 5 * lines);
        chk(dark_c == lines * 4 + 8 * grp, "R8 dark samples", dark_c, lines * 4 + 8 * grp);
        chk(act_c == r * grp, "R9 active binned samples", act_c, r * grp);
        chk(samp_c == lines * (4 + grp), "R9 total samples", samp_c, lines * (4 + grp));
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held and after release
        chk(!v1 && !v2 && h1 && !h2 && !rg && !sample && tag == 2'd0 && !busy && !frame_done,
            "R1 state in reset", int'({v1, v2, h1, h2, rg, sample, busy, frame_done}), 32);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!v1 && !v2 && h1 && !h2 && !rg && !sample && tag == 2'd0 && !busy,
            "R1 idle after reset", int'({v1, v2, h1, h2, rg, sample, busy}), 16);
        for (int i = 0; i < NVEC; i++)
            run_frame(V_ROWS[i], V_COLS[i], V_BIN[i], V_EXP[i], V_GAP[i], 1'b0);
        // R11: start during a frame leaves the frame unchanged
        run_frame(2, 4, 1, 3, 0, 1'b1);
        // R9: bin larger than a line and uneven groups once more
        run_frame(1, 5, 7, 0, 1, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule